// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder (rate 1/2, K=3)

This block recovers a message from a rate-1/2 convolutional code of constraint length 3, working on hard (one bit per coded bit) decisions. Before each frame a load strobe supplies the two 3-bit tap vectors of the code and resets the trellis. The block then accepts one 2-bit received symbol per handshake until a symbol marked as last arrives. For each symbol it forms Hamming distances against the expected branch outputs derived from the loaded taps, runs add-compare-select over the four trellis states, and records one survivor decision per state per step.

When the frame ends, the block picks the end state with the smallest path metric, walks the stored decisions back to the first step, and then streams the decoded bits out in their original order over a valid/ready interface. A single-cycle done flag follows the final bit. Both data interfaces obey the usual stream rules: a transfer happens on a rising edge where valid and ready are both high; the decoder raises `sym_ready` only while it is collecting a frame, and once `bit_valid` is high it holds it and `bit_data` unchanged until `bit_ready` takes the bit. The load strobe and done flag are plain control pins.

Top module: `vit_hard_dec`

## Requirements
- R1: A high `cfg_load` on a rising edge latches `cfg_poly_a` and `cfg_poly_b` and starts a frame; `sym_ready` is high from the following cycle, except in any cycle where `cfg_load` is high. Tap bit 2 selects the current input bit, bit 1 the previous input bit, bit 0 the one before.
- R2: The code convention is: the encoder starts in state 0; state bit 1 is the previous input bit and bit 0 the one before; each step the shift register moves right so the next state is {input, state[1]}. `sym_data[1]` is the parity of poly A's taps and `sym_data[0]` of poly B's. A frame received without errors, for any tap pair with bit 2 set in both, decodes to the sent message.
- R3: The branch metric is the Hamming distance (0, 1 or 2) between received and expected symbol, and at a merge the path with the lower accumulated metric survives; with taps 111/101 and message 1,1,1,0 the decoder returns 1,1,1,0 even with one coded bit flipped.
- R4: After a load, state 0 holds metric 0 and every other state 255; path metrics are 8 bits and saturate at 255 instead of wrapping, and the smallest metric never decreases from one step to the next. With taps 111/101, a one-symbol frame `11` decodes to 1.
- R5: Ties resolve to the lower number: at a merge the predecessor with the lower state number is kept, and at frame end the lowest-numbered state among those with the minimum metric is chosen. With taps 111/101, a one-symbol frame `01` decodes to 0.
- R6: A frame holds 1 to 64 symbols; a 64-symbol frame with one isolated coded-bit error in its middle decodes correctly.
- R7: Decoded bits leave in message order, one per `bit_valid`/`bit_ready` transfer; while `bit_valid` is high and `bit_ready` low, `bit_valid` and `bit_data` stay unchanged.
- R8: `frame_done` is high for exactly one cycle, the cycle after the transfer of the frame's final bit.
- R9: `sym_ready` is low outside symbol collection (after reset, during traceback, during output, after done); `bit_valid` is low until traceback completes; the two are never high together.
- R10: `cfg_load` at any time abandons the frame in progress: none of its bits are emitted and the new frame decodes on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Frame start and tap-vector load strobe |
| cfg_poly_a | input | 3 | Tap vector for coded bit 1 |
| cfg_poly_b | input | 3 | Tap vector for coded bit 0 |
| sym_valid | input | 1 | Received symbol is valid |
| sym_ready | output | 1 | Decoder accepts a symbol this cycle |
| sym_data | input | 2 | Received hard-decision symbol {A, B} |
| sym_last | input | 1 | Marks the final symbol of the frame |
| bit_valid | output | 1 | Decoded bit is valid |
| bit_ready | input | 1 | Downstream takes the decoded bit |
| bit_data | output | 1 | Decoded message bit |
| frame_done | output | 1 | One-cycle pulse after the final bit |

## Verification
The checker assumes the source never offers more than 64 symbols in a frame without marking one as last, and that `cfg_load` is not raised while a stalled output bit is waiting, since a load legitimately drops that bit. The stimulus honours both: every frame is at most 64 symbols with the last one flagged, and loads occur only while the decoder is idle or still collecting symbols. Random gaps on `sym_valid` and random stalls on `bit_ready` exercise the hold rules of both stream interfaces within those limits.

// File: rtl/vit_pkg.sv
package vit_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_RECV,
    FS_PICK,
    FS_TRACE,
    FS_EMIT
  } vit_fsm_e;

  // Distance between two 2-bit hard symbols: 0, 1 or 2.
  function automatic logic [1:0] sym_distance(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] d;
    d = a ^ b;
    return {d[1] & d[0], d[1] ^ d[0]};
  endfunction

endpackage

// File: rtl/vit_bmu.sv
// Branch metric unit: expected outputs are derived from the loaded taps.
module vit_bmu #(
  parameter int K  = 3,
  parameter int NS = 1 << (K - 1)
) (
  input  logic [K-1:0]              poly_a,
  input  logic [K-1:0]              poly_b,
  input  logic [1:0]                sym,
  output logic [NS-1:0][1:0][1:0]   bm
);
  import vit_pkg::*;

  for (genvar s = 0; s < NS; s++) begin : g_state
    for (genvar u = 0; u < 2; u++) begin : g_in
      // Shift register contents: {current input, state}
      localparam logic [K-1:0] RV = K'((u << (K - 1)) | s);
      logic [1:0] expv;
      assign expv      = {^(poly_a & RV), ^(poly_b & RV)};
      assign bm[s][u]  = sym_distance(expv, sym);
    end
  end

endmodule

// File: rtl/vit_acs.sv
// Add-compare-select over all states with saturating path metrics.
module vit_acs #(
  parameter int K  = 3,
  parameter int MW = 8,
  parameter int NS = 1 << (K - 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      init,
  input  logic                      step,
  input  logic [NS-1:0][1:0][1:0]   bm,
  output logic [NS-1:0][MW-1:0]     pm,
  output logic [NS-1:0]             dec
);
  localparam int HALF = NS / 2;
  localparam logic [MW-1:0] MAXV = '1;

  logic [NS-1:0][MW-1:0] pm_nx;

  for (genvar n = 0; n < NS; n++) begin : g_acs
    // Predecessors of state n are {n[low bits], x}; input bit is n's MSB.
    localparam int P0 = (n % HALF) * 2;
    localparam int P1 = P0 + 1;
    localparam int U  = n / HALF;
    logic [MW:0]   sum0, sum1;
    logic [MW-1:0] cand0, cand1;
    assign sum0  = {1'b0, pm[P0]} + {{(MW-1){1'b0}}, bm[P0][U]};
    assign sum1  = {1'b0, pm[P1]} + {{(MW-1){1'b0}}, bm[P1][U]};
    assign cand0 = sum0[MW] ? MAXV : sum0[MW-1:0];
    assign cand1 = sum1[MW] ? MAXV : sum1[MW-1:0];
    // Strictly lower wins; equal keeps the lower-numbered predecessor.
    assign dec[n]   = (cand1 < cand0);
    assign pm_nx[n] = dec[n] ? cand1 : cand0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : MAXV;
    end else if (init) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : MAXV;
    end else if (step) begin
      pm <= pm_nx;
    end
  end

endmodule

// File: rtl/vit_surv.sv
// Survivor decision store: one word of per-state decisions per trellis step.
module vit_surv #(
  parameter int NS    = 4,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NS-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [NS-1:0] rdata
);
  logic [NS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/vit_hard_dec.sv
module vit_hard_dec #(
  parameter int K     = 3,
  parameter int MW    = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_load,
  input  logic [K-1:0] cfg_poly_a,
  input  logic [K-1:0] cfg_poly_b,
  input  logic         sym_valid,
  output logic         sym_ready,
  input  logic [1:0]   sym_data,
  input  logic         sym_last,
  output logic         bit_valid,
  input  logic         bit_ready,
  output logic         bit_data,
  output logic         frame_done
);
  import vit_pkg::*;

  localparam int NS = 1 << (K - 1);
  localparam int SW = K - 1;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  vit_fsm_e     fsm_q;
  logic [K-1:0] poly_a_q, poly_b_q;
  logic [CW-1:0] cnt_q, emit_q;
  logic [AW-1:0] idx_q;
  logic [SW-1:0] tb_st_q, best;
  logic [DEPTH-1:0] obuf_q;
  logic          done_q;

  logic [NS-1:0][1:0][1:0] bm_w;
  logic [NS-1:0][MW-1:0]   pm_w;
  logic [NS-1:0]           dec_w, rd_dec;
  logic                    step;
  logic [MW-1:0]           bestv;

  assign sym_ready  = (fsm_q == FS_RECV) && !cfg_load;
  assign step       = sym_valid && sym_ready;
  assign bit_valid  = (fsm_q == FS_EMIT);
  assign bit_data   = obuf_q[emit_q[AW-1:0]];
  assign frame_done = done_q;

  vit_bmu #(.K(K), .NS(NS)) u_bmu (
    .poly_a (poly_a_q),
    .poly_b (poly_b_q),
    .sym    (sym_data),
    .bm     (bm_w)
  );

  vit_acs #(.K(K), .MW(MW), .NS(NS)) u_acs (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (cfg_load),
    .step  (step),
    .bm    (bm_w),
    .pm    (pm_w),
    .dec   (dec_w)
  );

  vit_surv #(.NS(NS), .DEPTH(DEPTH), .AW(AW)) u_surv (
    .clk   (clk),
    .we    (step),
    .waddr (cnt_q[AW-1:0]),
    .wdata (dec_w),
    .raddr (idx_q),
    .rdata (rd_dec)
  );

  // End-state selection: smallest metric, lowest index on ties.
  always_comb begin
    best  = '0;
    bestv = pm_w[0];
    for (int i = 1; i < NS; i++) begin
      if (pm_w[i] < bestv) begin
        best  = SW'(i);
        bestv = pm_w[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q    <= FS_IDLE;
      poly_a_q <= '0;
      poly_b_q <= '0;
      cnt_q    <= '0;
      emit_q   <= '0;
      idx_q    <= '0;
      tb_st_q  <= '0;
      obuf_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_load) begin
        fsm_q    <= FS_RECV;
        poly_a_q <= cfg_poly_a;
        poly_b_q <= cfg_poly_b;
        cnt_q    <= '0;
      end else begin
        unique case (fsm_q)
          FS_RECV: begin
            if (step) begin
              cnt_q <= cnt_q + CW'(1);
              if (sym_last) fsm_q <= FS_PICK;
            end
          end
          FS_PICK: begin
            tb_st_q <= best;
            idx_q   <= AW'(cnt_q - CW'(1));
            fsm_q   <= FS_TRACE;
          end
          FS_TRACE: begin
            // The newest input bit of a state is its MSB.
            obuf_q[idx_q] <= tb_st_q[SW-1];
            tb_st_q       <= {tb_st_q[SW-2:0], rd_dec[tb_st_q]};
            if (idx_q == '0) begin
              fsm_q  <= FS_EMIT;
              emit_q <= '0;
            end else begin
              idx_q <= idx_q - AW'(1);
            end
          end
          FS_EMIT: begin
            if (bit_ready) begin
              if (emit_q == cnt_q - CW'(1)) begin
                fsm_q  <= FS_IDLE;
                done_q <= 1'b1;
              end else begin
                emit_q <= emit_q + CW'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/vit_chk.sv
module vit_chk #(
  parameter int NS    = 4,
  parameter int MW    = 8,
  parameter int CW    = 7,
  parameter int DEPTH = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_load,
  input logic                  sym_valid,
  input logic                  sym_ready,
  input logic                  bit_valid,
  input logic                  bit_ready,
  input logic                  bit_data,
  input logic                  frame_done,
  input logic [NS-1:0][MW-1:0] pm,
  input logic [CW-1:0]         cnt
);
  logic [MW-1:0] min_pm;
  logic          init_ok;

  always_comb begin
    min_pm  = pm[0];
    init_ok = (pm[0] == '0);
    for (int i = 1; i < NS; i++) begin
      if (pm[i] < min_pm) min_pm = pm[i];
      if (pm[i] != {MW{1'b1}}) init_ok = 1'b0;
    end
  end

  // R4: metrics start at 0 for state 0 and the ceiling elsewhere
  assert_metric_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> init_ok);

  // R4: best metric never drops across a step (no wraparound)
  assert_min_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (min_pm >= $past(min_pm)));

  // R6: frame never exceeds the survivor depth
  assert_frame_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |-> (int'(cnt) < DEPTH));

  // R7: stalled output holds
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready && !cfg_load) |=> (bit_valid && $stable(bit_data)));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9: input and output phases never overlap
  assert_phase_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_ready && bit_valid));

endmodule

bind vit_hard_dec vit_chk #(.NS(NS), .MW(MW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .sym_valid  (sym_valid),
  .sym_ready  (sym_ready),
  .bit_valid  (bit_valid),
  .bit_ready  (bit_ready),
  .bit_data   (bit_data),
  .frame_done (frame_done),
  .pm         (pm_w),
  .cnt        (cnt_q)
);

// File: tb/sim_vit_hard_dec.sv
`timescale 1ns/1ps
module sim_vit_hard_dec;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [2:0] cfg_poly_a = '0;
  logic [2:0] cfg_poly_b = '0;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [1:0] sym_data = '0;
  logic       sym_last = 1'b0;
  logic       bit_valid;
  logic       bit_ready = 1'b0;
  logic       bit_data;
  logic       frame_done;

  always #2 clk = ~clk;

  vit_hard_dec u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_poly_a(cfg_poly_a), .cfg_poly_b(cfg_poly_b),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .sym_last(sym_last), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .frame_done(frame_done)
  );

  typedef struct {
    logic  b;
    logic  last;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic done_pend = 1'b0;
  logic stall_en  = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Reference encoder built from the R2 convention.
  function automatic logic [127:0] encode(input logic [2:0] ga, input logic [2:0] gb,
                                          input logic [63:0] msg, input int n);
    logic [127:0] c;
    logic [1:0]   st;
    logic [2:0]   r;
    c  = '0;
    st = 2'b00;
    for (int t = 0; t < n; t++) begin
      r          = {msg[t], st};
      c[2*t+1]   = ^(ga & r);
      c[2*t]     = ^(gb & r);
      st         = {msg[t], st[1]};
    end
    return c;
  endfunction

  task automatic send_syms(input logic [127:0] code, input int n, input bit gaps, input bit mark_last);
    for (int t = 0; t < n; t++) begin
      if (gaps && ($urandom % 3 == 0)) @(negedge clk);
      sym_valid = 1'b1;
      sym_data  = code[2*t +: 2];
      sym_last  = mark_last && (t == n - 1);
      while (!sym_ready) @(negedge clk);
      @(negedge clk);
      sym_valid = 1'b0;
      sym_last  = 1'b0;
    end
  endtask

  task automatic load(input logic [2:0] ga, input logic [2:0] gb);
    @(negedge clk);
    cfg_load   = 1'b1;
    cfg_poly_a = ga;
    cfg_poly_b = gb;
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
    chk(sym_ready == 1'b1, "R1 ready after load", int'(sym_ready), 1);
  endtask

  task automatic run_frame(input logic [2:0] ga, input logic [2:0] gb,
                           input logic [127:0] code, input int n,
                           input logic [63:0] expb, input string tag, input bit gaps);
    for (int i = 0; i < n; i++) q.push_back('{b: expb[i], last: (i == n - 1), tag: tag});
    load(ga, gb);
    send_syms(code, n, gaps, 1'b1);
    @(negedge clk);
    #1;
    chk(sym_ready == 1'b0, "R9 no ready after last", int'(sym_ready), 0);
    while (q.size() != 0 || done_pend) @(negedge clk);
    @(negedge clk);
    #1;
    chk(sym_ready == 1'b0, "R9 ready low after done", int'(sym_ready), 0);
    chk(bit_valid == 1'b0, "R9 valid low after done", int'(bit_valid), 0);
  endtask

  // Monitor: drives back-pressure and compares against the scoreboard.
  initial begin
    logic held_v;
    logic held_d;
    held_v = 1'b0;
    held_d = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (held_v) begin
        chk(bit_valid == 1'b1 && bit_data == held_d, "R7 hold under stall",
            int'(bit_data), int'(held_d));
      end
      if (done_pend) begin
        chk(frame_done == 1'b1, "R8 done after final bit", int'(frame_done), 1);
        done_pend = 1'b0;
      end else if (frame_done) begin
        chk(1'b0, "R8 stray done", 1, 0);
      end
      bit_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
      #1;
      held_v = bit_valid && !bit_ready;
      held_d = bit_data;
      if (bit_valid && bit_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected output bit", int'(bit_data), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(bit_data == e.b, e.tag, int'(bit_data), int'(e.b));
          if (e.last) done_pend = 1'b1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0]  msg;
    logic [127:0] code;

    repeat (4) @(negedge clk);
    #1;
    chk(sym_ready == 1'b0, "R9 reset ready", int'(sym_ready), 0);
    chk(bit_valid == 1'b0, "R9 reset valid", int'(bit_valid), 0);
    chk(frame_done == 1'b0, "R8 reset done", int'(frame_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(sym_ready == 1'b0, "R9 idle ready", int'(sym_ready), 0);

    // R2: taps 111/101, message 1,1,1,0 -> symbols 11 01 10 01
    run_frame(3'b111, 3'b101, 128'(8'b01_10_01_11), 4, 64'b0111, "R2 clean 1110", 1'b0);

    // R3: same frame, first symbol received as 01
    run_frame(3'b111, 3'b101, 128'(8'b01_10_01_01), 4, 64'b0111, "R3 one flipped bit", 1'b0);

    // R2: taps 111/110, message 1,0,0,1,1,0 with gaps and stalls
    stall_en = 1'b1;
    msg  = 64'b011001;
    code = encode(3'b111, 3'b110, msg, 6);
    run_frame(3'b111, 3'b110, code, 6, msg, "R2 taps 111/110", 1'b1);

    // R2: taps 110/101, message 1,1,0,1,0,1
    msg  = 64'b101011;
    code = encode(3'b110, 3'b101, msg, 6);
    run_frame(3'b110, 3'b101, code, 6, msg, "R2 taps 110/101", 1'b1);

    // R4: one symbol 11 with 111/101 must decode to 1 (no metric wrap)
    run_frame(3'b111, 3'b101, 128'(2'b11), 1, 64'b1, "R4 saturation", 1'b0);

    // R5: one symbol 01 ties states 0 and 2; lowest wins -> 0
    run_frame(3'b111, 3'b101, 128'(2'b01), 1, 64'b0, "R5 end-state tie", 1'b0);

    // R10: abandon a partial frame, then decode a fresh one
    load(3'b111, 3'b101);
    send_syms(128'(6'b10_01_11), 3, 1'b0, 1'b0);
    msg  = 64'b1011;
    code = encode(3'b111, 3'b101, msg, 4);
    run_frame(3'b111, 3'b101, code, 4, msg, "R10 restart", 1'b0);

    // R6: full-depth frame with one isolated error in the middle
    msg  = 64'hA5C3_1E97_5B2D_F048;
    code = encode(3'b111, 3'b101, msg, 64);
    code[41] = ~code[41];
    run_frame(3'b111, 3'b101, code, 64, msg, "R6 64-step frame", 1'b1);

    // R7: full-depth clean frame with heavy stalls, order check
    msg  = 64'h3C96_0FF1_2468_ACE5;
    code = encode(3'b111, 3'b110, msg, 64);
    run_frame(3'b111, 3'b110, code, 64, msg, "R7 order under stalls", 1'b1);

    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule